// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 through 15, and gives each of a parameterized number of processors one 4-bit request level. A processor's level is the number of its most urgent request. Zero means nothing is requested.

A line that rises is recorded in one of two places. Normally it goes into a pending register that all processors share. If the line is marked for broadcast, it goes instead into a private force register held by every processor. Each processor keeps a mask of the lines it accepts. A shared priority-select register splits that processor's accepted requests into a high group and a low group. The block is configured and observed through a 32-bit APB-style register port that covers a 256-byte window.

An acknowledge port carries a processor index and an interrupt number. It retires that interrupt from the pending register and from that processor's force register.

Top module: `irq_hub`

## Requirements
- R1: After reset every register reads 0 and every processor's request level is 0.
- R2: Bit 0 is never an interrupt. Writes keep only bits 15:1 in the priority-select register (0x00), the broadcast register (0x14), the mask registers (0x40 + 4*p) and the force registers. Bit 0 of the irq_in port is ignored.
- R3: A rising edge on line n, after a two-flop synchronizer, sets pending bit n when broadcast bit n is 0. The request level follows within 5 cycles of the input change. A line held high does not set the bit again after it has been acknowledged.
- R4: A rising edge on line n with broadcast bit n set sets bit n in every processor's force register, read at 0x80 + 4*p, and leaves pending bit n unchanged.
- R5: A processor's candidates are (pending OR force) AND mask. Its request level is the highest candidate number, or 0 when there are no candidates. The level is registered, so it follows a state change by one cycle.
- R6: When any candidate has its priority-select bit set, only those candidates are encoded. Lower-numbered high-group lines therefore override higher-numbered low-group lines.
- R7: A write to 0x80 + 4*p sets the force bits given in data[15:1] and clears the force bits given in data[31:17]. Clear wins over set.
- R8: A write to 0x08 replaces processor 0's force register with data[15:1]. Offset 0x08 reads back processor 0's force register.
- R9: A write to 0x0C clears every pending bit written as 1. Offset 0x0C reads as 0.
- R10: The pending register (0x04) and the status word (0x10) ignore writes. 0x10 and every unmapped offset read as 0.
- R11: An acknowledge of number n from processor p clears pending bit n and bit n of processor p's force register only.
- R12: The per-processor extra registers at 0xC0 + 4*p keep only data[3:0].
- R13: When a new request and a clear-register write or acknowledge hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational on paddr) |
| irq_in | input | 16 | Request lines, bit 0 ignored |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | Acknowledging processor |
| ack_num | input | 4 | Acknowledged interrupt number |
| irq_level | output | 4*NCPU | Request level per processor, processor p in bits 4p+3:4p |

## Verification
The hardest case to reach is R13, where a synchronized rising edge lands in the same clock edge as a clear-register write to the same bit. The edge pulse only exists one cycle, two cycles after the input changes. The bench therefore raises the line on a falling edge and begins the register write one cycle later. This puts the access phase exactly in the cycle where the pulse is live. It then reads the pending register and expects the bit set, while an ordinary clear of the same bit was shown to work just before.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int IRQ_W = 16;
  localparam int LVL_W = 4;
  localparam logic [IRQ_W-1:0] IRQ_VALID = 16'hFFFE;

  // highest set bit number among 15..1, zero when none
  function automatic logic [LVL_W-1:0] top_bit(input logic [IRQ_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < IRQ_W; i++)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  // high group wins whenever it has anything in it
  function automatic logic [IRQ_W-1:0] pick_group(input logic [IRQ_W-1:0] cand,
                                                  input logic [IRQ_W-1:0] hi_sel);
    logic [IRQ_W-1:0] hi;
    hi = cand & hi_sel;
    return (hi != '0) ? hi : (cand & ~hi_sel);
  endfunction

  // set from the low half, clear from the high half; clear dominates
  function automatic logic [IRQ_W-1:0] force_merge(input logic [IRQ_W-1:0] old,
                                                   input logic [31:0] wd);
    return (old | wd[IRQ_W-1:0]) & ~wd[31:16] & IRQ_VALID;
  endfunction
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync
  import irq_hub_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_in,
  output logic [IRQ_W-1:0] rise
);
  logic [IRQ_W-1:0] stg [STAGES+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= irq_in;
      for (int k = 1; k <= STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign rise = stg[STAGES-1] & ~stg[STAGES] & IRQ_VALID;
endmodule

// File: rtl/irq_hub_cpu.sv
module irq_hub_cpu
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] hi_sel,
  input  logic [31:0]      wdata,
  input  logic             mask_wr,
  input  logic             force_wr,
  input  logic             alias_wr,
  input  logic             ext_wr,
  input  logic             ack_hit,
  input  logic [IRQ_W-1:0] ack_bits,
  input  logic [IRQ_W-1:0] bc_set,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] force_q,
  output logic [3:0]       ext_q,
  output logic [IRQ_W-1:0] cand,
  output logic [LVL_W-1:0] level
);
  logic [IRQ_W-1:0] force_n;

  always_comb begin
    force_n = force_q;
    if (alias_wr)      force_n = wdata[IRQ_W-1:0] & IRQ_VALID;
    else if (force_wr) force_n = force_merge(force_q, wdata);
    if (ack_hit)       force_n = force_n & ~ack_bits;
    force_n = (force_n | bc_set) & IRQ_VALID;
  end

  assign cand = (pend | force_q) & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      force_q <= '0;
      ext_q   <= '0;
      level   <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata[IRQ_W-1:0] & IRQ_VALID;
      if (ext_wr)  ext_q  <= wdata[3:0];
      force_q <= force_n;
      level   <= top_bit(pick_group(cand, hi_sel));
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int STAGES = 2,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [7:0]            paddr,
  input  logic [31:0]           pwdata,
  output logic [31:0]           prdata,
  input  logic [IRQ_W-1:0]      irq_in,
  input  logic                  ack_valid,
  input  logic [CPU_W-1:0]      ack_cpu,
  input  logic [3:0]            ack_num,
  output logic [NCPU*LVL_W-1:0] irq_level
);
  logic [IRQ_W-1:0] rise, pend_q, hi_q, bcast_q, ack_bits, bc_set, clr_bits;
  logic [IRQ_W-1:0] mask_v [NCPU];
  logic [IRQ_W-1:0] force_v [NCPU];
  logic [IRQ_W-1:0] cand_v [NCPU];
  logic [3:0]       ext_v [NCPU];
  logic             wr_en, wr_hi, wr_pend, wr_alias, wr_clr, wr_bc;
  logic [IRQ_W-1:0] force0_w, cand0_w;

  irq_hub_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
  );

  assign wr_en    = psel && penable && pwrite && (paddr[1:0] == 2'b00);
  assign wr_hi    = wr_en && (paddr == 8'h00);
  assign wr_pend  = wr_en && (paddr == 8'h04);
  assign wr_alias = wr_en && (paddr == 8'h08);
  assign wr_clr   = wr_en && (paddr == 8'h0C);
  assign wr_bc    = wr_en && (paddr == 8'h14);

  assign ack_bits = ack_valid ? (IRQ_W'(1) << ack_num) : '0;
  assign clr_bits = wr_clr ? pwdata[IRQ_W-1:0] : '0;
  assign bc_set   = rise & bcast_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      hi_q    <= '0;
      bcast_q <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr_bits & ~ack_bits) | (rise & ~bcast_q)) & IRQ_VALID;
      if (wr_hi) hi_q    <= pwdata[IRQ_W-1:0] & IRQ_VALID;
      if (wr_bc) bcast_q <= pwdata[IRQ_W-1:0] & IRQ_VALID;
    end
  end

  for (genvar p = 0; p < NCPU; p++) begin : g_cpu
    logic slot_hit;
    assign slot_hit = wr_en && (paddr[5:2] == 4'(p));
    irq_hub_cpu u_cpu (
      .clk(clk), .rst_n(rst_n), .pend(pend_q), .hi_sel(hi_q), .wdata(pwdata),
      .mask_wr (slot_hit && (paddr[7:6] == 2'b01)),
      .force_wr(slot_hit && (paddr[7:6] == 2'b10)),
      .alias_wr(wr_alias && (p == 0)),
      .ext_wr  (slot_hit && (paddr[7:6] == 2'b11)),
      .ack_hit (ack_valid && (ack_cpu == CPU_W'(p))),
      .ack_bits(ack_bits), .bc_set(bc_set),
      .mask_q(mask_v[p]), .force_q(force_v[p]), .ext_q(ext_v[p]),
      .cand(cand_v[p]), .level(irq_level[p*LVL_W +: LVL_W])
    );
  end

  assign force0_w = force_v[0];
  assign cand0_w  = cand_v[0];

  always_comb begin
    prdata = '0;
    if (paddr[1:0] == 2'b00) begin
      if (paddr[7:6] == 2'b00) begin
        case (paddr[5:0])
          6'h00:   prdata = 32'(hi_q);
          6'h04:   prdata = 32'(pend_q);
          6'h08:   prdata = 32'(force_v[0]);
          6'h14:   prdata = 32'(bcast_q);
          default: prdata = '0;
        endcase
      end else begin
        for (int p = 0; p < NCPU; p++) begin
          if (paddr[5:2] == 4'(p)) begin
            case (paddr[7:6])
              2'b01:   prdata = 32'(mask_v[p]);
              2'b10:   prdata = 32'(force_v[p]);
              default: prdata = 32'(ext_v[p]);
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rise,
  input logic [15:0] bcast_q,
  input logic [15:0] pend_q,
  input logic [15:0] hi_q,
  input logic [15:0] force0,
  input logic [15:0] cand0,
  input logic [3:0]  level0,
  input logic        ack_valid,
  input logic [3:0]  ack_num,
  input logic        wr_clr,
  input logic        wr_pend,
  input logic [31:0] pwdata
);
  assert_ack_clears_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !rise[ack_num]) |=> !pend_q[$past(ack_num)]);

  assert_clear_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pend_q & $past(pwdata[15:0] & ~rise)) == 16'h0));

  assert_pending_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !ack_valid && rise == 16'h0) |=> $stable(pend_q));

  assert_broadcast_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & bcast_q) != 16'h0) |=> ((force0 & $past(rise & bcast_q)) == $past(rise & bcast_q)));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand0 == 16'h0) |=> (level0 == 4'h0));

  assert_high_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand0 & hi_q) != 16'h0) |=> (($past(hi_q) & (16'h1 << level0)) != 16'h0));
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .bcast_q(bcast_q), .pend_q(pend_q),
  .hi_q(hi_q), .force0(force0_w), .cand0(cand0_w), .level0(irq_level[3:0]),
  .ack_valid(ack_valid), .ack_num(ack_num), .wr_clr(wr_clr), .wr_pend(wr_pend),
  .pwdata(pwdata)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [15:0] irq_in = '0;
  logic        ack_valid = 1'b0;
  logic [0:0]  ack_cpu = '0;
  logic [3:0]  ack_num = '0;
  logic [7:0]  irq_level;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_hub #(.NCPU(2)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_num(ack_num), .irq_level(irq_level)
  );

  // write-then-readback vectors: offset, data written, value expected back, requirement
  localparam int NV = 13;
  localparam logic [7:0]  VA [NV] = '{8'h00, 8'h14, 8'h14, 8'h40, 8'h44, 8'hC0, 8'hC4,
                                      8'h04, 8'h10, 8'h0C, 8'h20, 8'h08, 8'h80};
  localparam logic [31:0] VW [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF,
                                      32'h0000_1234, 32'h0000_00FF, 32'h0000_ABC5,
                                      32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000};
  localparam logic [31:0] VE [NV] = '{32'hFFFE, 32'hFFFE, 32'h0, 32'hFFFE, 32'h1234,
                                      32'hF, 32'h5, 32'h0, 32'h0, 32'h0, 32'h0,
                                      32'hFFFE, 32'h0};
  // R2 x5, R12 x2, R10, R10, R9, R10, R8, R7
  localparam int          VR [NV] = '{2, 2, 2, 2, 2, 12, 12, 10, 10, 9, 10, 8, 7};

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic ack(input logic c, input logic [3:0] n);
    @(negedge clk); ack_valid = 1; ack_cpu = c; ack_num = n;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    idle(2);
    rst_n = 1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check(1, 32'(irq_level), 32'h0);
    rd(8'h00, d); check(1, d, 32'h0);
    rd(8'h80, d); check(1, d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VW[i]);
      rd(VA[i], d);
      check(VR[i], d, VE[i]);
    end

    do_reset();
    rd(8'h40, d); check(1, d, 32'h0);  // R1 again after reset

    // R3: rising line sets pending, level follows
    wr(8'h40, 32'h0000_FFFE);
    @(negedge clk); irq_in[5] = 1; irq_in[0] = 1;  // bit 0 ignored, R2
    idle(5);
    check(3, 32'(irq_level[3:0]), 32'd5);
    rd(8'h04, d); check(3, d, 32'h0020);
    check(5, 32'(irq_level[7:4]), 32'd0);  // R5 processor 1 masks everything

    @(negedge clk); irq_in[9] = 1;
    idle(5);
    check(5, 32'(irq_level[3:0]), 32'd9);  // R5 highest number wins
    wr(8'h44, 32'h0000_0020);
    idle(2);
    check(5, 32'(irq_level[7:4]), 32'd5);

    // R11 acknowledge, R3 held line stays retired
    ack(1'b0, 4'd9);
    idle(5);
    rd(8'h04, d); check(11, d, 32'h0020);
    check(3, 32'(irq_level[3:0]), 32'd5);

    // R6 high group overrides
    @(negedge clk); irq_in[12] = 1;
    idle(5);
    check(5, 32'(irq_level[3:0]), 32'd12);
    wr(8'h00, 32'h0000_0020);
    idle(2);
    check(6, 32'(irq_level[3:0]), 32'd5);
    wr(8'h00, 32'h0);

    // R7 set/clear force write, clear wins
    wr(8'h84, 32'h0010_0018);
    rd(8'h84, d); check(7, d, 32'h0008);
    wr(8'h84, 32'h0008_0008);
    rd(8'h84, d); check(7, d, 32'h0);

    // R8 alias replaces
    wr(8'h80, 32'h0000_0004);
    wr(8'h08, 32'h0000_0002);
    rd(8'h80, d); check(8, d, 32'h0002);
    wr(8'h08, 32'h0);

    // R4 broadcast
    wr(8'h14, 32'h0000_0080);
    @(negedge clk); irq_in[7] = 1;
    idle(5);
    rd(8'h80, d); check(4, d, 32'h0080);
    rd(8'h84, d); check(4, d, 32'h0080);
    rd(8'h04, d); check(4, d, 32'h1020);

    // R11 acknowledge touches only its own processor
    ack(1'b1, 4'd7);
    rd(8'h84, d); check(11, d, 32'h0);
    rd(8'h80, d); check(11, d, 32'h0080);

    // R9 clear register
    @(negedge clk); irq_in[12] = 0;
    idle(5);
    wr(8'h0C, 32'h0000_1020);
    rd(8'h04, d); check(9, d, 32'h0);

    // R13 new request coincides with a clear of the same bit
    @(negedge clk); irq_in[12] = 1;
    @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h0C; pwdata = 32'h0000_1000;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    rd(8'h04, d); check(13, d, 32'h1000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule